// File: doc/BRIEF.md
# Masked-Write Random-Bit Harvester

This block is a register-mapped random-number harvester. Software sets a sampling interval, an output length and an oscillator-ring choice, turns the block on, and then raises a start flag. The block then takes one bit from an external noise input at each sampling interval. It packs those bits into a bank of 32-bit output words, starting at word 0. When the last requested bit has been taken, the start flag drops by itself, and software reads the words.

The control register takes masked writes. The upper half of every write word is a per-bit write enable for the lower half, so one field can be changed without a read-modify-write. A write of all-zero data under a full mask turns the block off and stops any harvest in progress. The noise input is a plain port, so any entropy source, or a test stand-in, can drive it.

Top module: `rng_ctl_engine`

## Requirements
- R1: After reset, the control register, the interval register and every output word read as zero.
- R2: On a write to address 0x00, control bit k (0..15) takes write-data bit k only when write-data bit k+16 is 1; otherwise bit k keeps its value.
- R3: Control bit 0 is the start flag and bit 1 is the enable. Bits [3:2] hold the ring choice, and bits [5:4] hold the length code (0, 1, 2, 3 give 64, 128, 192, 256 bits). Bits [15:6] are plain storage. Every field reads back as written.
- R4: A start request is taken only if the enable is 1 after the same write is applied; otherwise the start flag stays 0 and no harvest begins.
- R5: After a start is accepted on clock edge E0, the start flag reads 1 until it clears on edge E0+(S+1)·L, where S is the interval and L is the length in bits.
- R6: The interval register at 0x04 keeps the low 16 bits of its write data. During a harvest, one noise bit is taken on every (S+1)-th edge after E0.
- R7: The j-th bit taken (j from 0) is stored in output word j/32 at bit j%32. Output word i is read at address 0x10+4·i.
- R8: Accepting a start clears all output words, so words beyond the requested length read 0.
- R9: While a harvest runs, writes to the start flag are ignored, including a write on the edge that ends the harvest. A length-field change made during a harvest does not change the length of that harvest.
- R10: Writing 0xFFFF0000 to address 0x00 clears the whole control register and stops a running harvest at once. Bits already stored stay as they are, and no further bits are stored.
- R11: A read returns data on bus_rdata one cycle after bus_rd, showing the register values just before that edge. Unmapped or misaligned addresses read 0. bus_rdata holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data; the upper half is the mask for control writes |
| bus_rdata | output | 32 | Registered read data |
| noise_bit | input | 1 | Raw entropy bit to be sampled |

## Verification
Two events can land on one edge: the capture of the final bit, which clears the start flag, and a software write that sets the start flag again. The bench finds that edge from the interval and the length, then issues a masked start write timed to hit it exactly. It judges the result by reading the start flag back as 0 and by seeing that the output words still hold the finished harvest instead of being cleared by a second launch. A second case issues an off-write 50 edges into a 256-bit harvest. The bench checks that the bits taken up to and including that edge are kept and that nothing is stored after it.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;
  // control field positions (software decodes these)
  localparam int unsigned CTL_START = 0;
  localparam int unsigned CTL_EN    = 1;
  localparam int unsigned LEN_LO    = 4;

  localparam logic [7:0] ADR_CTL   = 8'h00;
  localparam logic [7:0] ADR_SCNT  = 8'h04;
  localparam logic [7:0] ADR_WORD0 = 8'h10;

  // length code to number of harvested bits
  function automatic int unsigned len_bits(input logic [1:0] code);
    return (32'(code) + 32'd1) * 32'd64;
  endfunction
endpackage

// File: rtl/rng_ctl_regs.sv
module rng_ctl_regs
  import rng_ctl_pkg::*;
#(
  parameter int SCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctl,
  input  logic              wr_scnt,
  input  logic [31:0]       wdata,
  input  logic              done,
  output logic [15:0]       ctl_q,
  output logic [SCNT_W-1:0] scnt_q,
  output logic              launch,
  output logic [1:0]        launch_len
);
  logic [15:0] mask, merged, nxt;
  logic        busy;

  assign busy = ctl_q[CTL_START];

  always_comb begin
    mask   = wdata[31:16];
    merged = (ctl_q & ~mask) | (wdata[15:0] & mask);
    nxt    = wr_ctl ? merged : ctl_q;
    if (busy)
      // running: start only drops (finish or enable removed)
      nxt[CTL_START] = nxt[CTL_EN] & ~done;
    else
      nxt[CTL_START] = wr_ctl & mask[CTL_START] & wdata[CTL_START] & nxt[CTL_EN];
  end

  assign launch     = ~busy & nxt[CTL_START];
  assign launch_len = nxt[LEN_LO+1:LEN_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      scnt_q <= '0;
    end else begin
      ctl_q <= nxt;
      if (wr_scnt) scnt_q <= wdata[SCNT_W-1:0];
    end
  end

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CTL_START] |-> ctl_q[CTL_EN]); // R4
  AST_DONE_DROPS_START: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |=> !ctl_q[CTL_START]); // R5
  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wdata[31:18] == '0) |=> $stable(ctl_q[15:2])); // R2
  AST_BUSY_KEEPS_START: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && !(wr_ctl && wdata[16+CTL_EN] && !wdata[CTL_EN])) |=> ctl_q[CTL_START]); // R9
endmodule

// File: rtl/rng_sampler.sv
module rng_sampler
  import rng_ctl_pkg::*;
#(
  parameter int SCNT_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [1:0]        launch_len,
  input  logic              run,
  input  logic [SCNT_W-1:0] scnt,
  output logic              cap,
  output logic [IDX_W-1:0]  idx,
  output logic              done
);
  logic [SCNT_W-1:0] cnt;
  logic [IDX_W-1:0]  last_q;
  logic              hit;

  // >= keeps the interval safe if software shrinks it mid-harvest
  assign hit  = (cnt >= scnt);
  assign cap  = run & hit;
  assign done = cap & (idx == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      idx    <= '0;
      last_q <= '0;
    end else if (launch) begin
      cnt    <= '0;
      idx    <= '0;
      last_q <= IDX_W'(len_bits(launch_len) - 32'd1);
    end else if (run) begin
      if (hit) begin
        cnt <= '0;
        idx <= idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (idx <= last_q)); // R5
  AST_CNT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    cap |=> (cnt == '0)); // R6
endmodule

// File: rtl/rng_out_words.sv
module rng_out_words #(
  parameter int DATA_W = 32,
  parameter int NWORDS = 8,
  parameter int IDX_W  = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              cap,
  input  logic [IDX_W-1:0]  idx,
  input  logic              noise,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] word
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [NWORDS-1:0][DATA_W-1:0] words;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      words <= '0;
    end else if (cap) begin
      words[idx[IDX_W-1:BIT_W]][idx[BIT_W-1:0]] <= noise;
    end
  end

  assign word = words[sel];

  AST_CLEAR_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    clear |=> (words[NWORDS-1] == '0)); // R8
endmodule

// File: rtl/rng_ctl_engine.sv
module rng_ctl_engine
  import rng_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SCNT_W = 16,
  parameter int NWORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              noise_bit
);
  localparam int DATA_W = 32;
  localparam int TOTAL  = NWORDS * DATA_W;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int SEL_W  = $clog2(NWORDS);

  logic [15:0]       ctl_q;
  logic [SCNT_W-1:0] scnt_q;
  logic              launch, cap, done;
  logic [1:0]        launch_len;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] woff;
  logic              hit_ctl, hit_scnt, hit_word;
  logic [DATA_W-1:0] word;

  assign hit_ctl  = (bus_addr == ADDR_W'(ADR_CTL));
  assign hit_scnt = (bus_addr == ADDR_W'(ADR_SCNT));
  assign woff     = bus_addr - ADDR_W'(ADR_WORD0);
  assign hit_word = (bus_addr >= ADDR_W'(ADR_WORD0)) &&
                    (woff[ADDR_W-1:SEL_W+2] == '0) && (woff[1:0] == 2'b00);

  rng_ctl_regs #(.SCNT_W(SCNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_ctl(bus_wr && hit_ctl), .wr_scnt(bus_wr && hit_scnt),
    .wdata(bus_wdata), .done(done),
    .ctl_q(ctl_q), .scnt_q(scnt_q),
    .launch(launch), .launch_len(launch_len)
  );

  rng_sampler #(.SCNT_W(SCNT_W), .IDX_W(IDX_W)) u_samp (
    .clk(clk), .rst(rst),
    .launch(launch), .launch_len(launch_len),
    .run(ctl_q[CTL_START]), .scnt(scnt_q),
    .cap(cap), .idx(idx), .done(done)
  );

  rng_out_words #(.DATA_W(DATA_W), .NWORDS(NWORDS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_words (
    .clk(clk), .rst(rst),
    .clear(launch), .cap(cap), .idx(idx), .noise(noise_bit),
    .sel(woff[SEL_W+1:2]), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (hit_ctl)       bus_rdata <= {16'h0000, ctl_q};
      else if (hit_scnt) bus_rdata <= 32'(scnt_q);
      else if (hit_word) bus_rdata <= word;
      else               bus_rdata <= '0;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

// File: tb/rng_ctl_engine_bench.sv
`timescale 1ns/1ps
module rng_ctl_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        noise_bit = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_e = 0;
  bit hist [0:65535];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  rng_ctl_engine u_rng_ctl_engine (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .noise_bit(noise_bit)
  );

  // noise stand-in changes away from the active edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    noise_bit = lfsr[0];
  end

  // log the noise value present at each rising edge
  always @(posedge clk) begin
    hist[cyc & 65535] = noise_bit;
    cyc = cyc + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr_at(input int k, input logic [7:0] a, input logic [31:0] d);
    while (cyc < k) @(negedge clk);
    last_e = cyc;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_at(cyc, a, d);
  endtask

  task automatic rd_at(input int k, input logic [7:0] a, output logic [31:0] v);
    while (cyc < k) @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_at(cyc, a, v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input int e0, input int s, input int l,
                                           input int lim, input int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) begin
      int j = w * 32 + b;
      int e = e0 + (s + 1) * (j + 1);
      if (j < l && e <= lim) v[b] = hist[e & 65535];
    end
    return v;
  endfunction

  task automatic check_words(input string req, input int e0, input int s,
                             input int l, input int lim);
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      rd(8'h10 + 8'(4 * w), v);
      check(req, v, exp_word(e0, s, l, lim, w));
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 ctl", v, 32'h0);
    rd(8'h04, v); check("R1 scnt", v, 32'h0);
    rd(8'h10, v); check("R1 word0", v, 32'h0);
    rd(8'h2C, v); check("R1 word7", v, 32'h0);
  endtask

  task automatic t_masked;
    logic [31:0] v;
    wr(8'h00, 32'hFFFC_ABCC);
    rd(8'h00, v); check("R2/R3 full mask upper bits", v, 32'h0000_ABCC);
    wr(8'h00, 32'h00F0_0000);
    rd(8'h00, v); check("R2 partial mask", v, 32'h0000_AB0C);
    check("R3 ring field", 32'(v[3:2]), 32'd3);
    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00, v); check("R2 empty mask", v, 32'h0000_AB0C);
    wr(8'h00, 32'hFFFF_0000);
    rd(8'h00, v); check("R10 off write", v, 32'h0);
  endtask

  task automatic t_start_gate;
    logic [31:0] v;
    int e0;
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0003_0001);
    rd(8'h00, v); check("R4 start without enable", v, 32'h0);
    idle(70);
    rd(8'h10, v); check("R4 no harvest", v, 32'h0);
    wr(8'h00, 32'h0002_0002);
    rd(8'h00, v); check("R4 enable alone", v, 32'h2);
    wr(8'h00, 32'h0001_0001);
    e0 = last_e;
    rd_at(e0 + 64, 8'h00, v); check("R5 start high on last edge", 32'(v[0]), 32'd1);
    rd_at(e0 + 65, 8'h00, v); check("R5 start cleared", v, 32'h2);
    check_words("R7/R8 64-bit harvest", e0, 0, 64, e0 + 64);
  endtask

  task automatic run_len(input int len, input int s);
    logic [31:0] v;
    int e0, l;
    l = (len + 1) * 64;
    wr(8'h04, 32'(s));
    wr(8'h00, {16'h0033, 10'b0, 2'(len), 2'b00, 2'b11});
    e0 = last_e;
    rd_at(e0 + (s + 1) * l, 8'h00, v); check("R5/R6 busy at end", 32'(v[0]), 32'd1);
    rd(8'h00, v); check("R5/R6 done", 32'(v[0]), 32'd0);
    check("R3 length code", 32'(v[5:4]), 32'(len));
    check_words("R6/R7/R8 harvest", e0, s, l, e0 + (s + 1) * l);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    int e0;
    wr(8'h04, 32'd1);
    wr(8'h00, 32'h0033_0003);
    e0 = last_e;
    wr_at(e0 + 40, 8'h00, 32'h0031_0031);
    rd(8'h00, v); check("R9 start kept, field stored", v, 32'h0000_0033);
    rd_at(e0 + 128, 8'h00, v); check("R9 original end", 32'(v[0]), 32'd1);
    rd(8'h00, v); check("R9 ends on old length", 32'(v[0]), 32'd0);
    check_words("R9 length latched", e0, 1, 64, e0 + 128);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    int e0;
    wr(8'h04, 32'd0);
    wr(8'h00, 32'h0033_0003);
    e0 = last_e;
    wr_at(e0 + 64, 8'h00, 32'h0001_0001);
    rd(8'h00, v); check("R9 start write on final edge", 32'(v[0]), 32'd0);
    idle(80);
    check_words("R9 no relaunch", e0, 0, 64, e0 + 64);
    wr(8'h00, 32'h0001_0001);
    rd(8'h00, v); check("R4 later start accepted", 32'(v[0]), 32'd1);
    idle(70);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    int e0;
    wr(8'h04, 32'd2);
    wr(8'h00, 32'h0033_0033);
    e0 = last_e;
    wr_at(e0 + 50, 8'h00, 32'hFFFF_0000);
    rd(8'h00, v); check("R10 off stops", v, 32'h0);
    idle(40);
    check_words("R10 partial words frozen", e0, 2, 256, e0 + 50);
    rd(8'h00, v); check("R10 stays off", v, 32'h0);
  endtask

  task automatic t_bus;
    logic [31:0] v;
    wr(8'h04, 32'h0001_2345);
    rd(8'h04, v); check("R6 interval width", v, 32'h0000_2345);
    rd(8'h08, v); check("R11 unmapped", v, 32'h0);
    rd(8'h30, v); check("R11 past words", v, 32'h0);
    rd(8'h11, v); check("R11 misaligned", v, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked();
    t_start_gate();
    run_len(3, 3);
    run_len(1, 2);
    run_len(2, 1);
    t_busy_ignore();
    t_collide();
    t_abort();
    t_bus();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule